// File: doc/BRIEF.md
# Outstanding Miss Buffer for a Write-Through Data Cache

This block keeps track of the requests that a nonblocking write-through data cache has handed to the next level. Each missed load and each store takes one slot of a small ring of entries. Slots are taken in arrival order. A drain stage sends the slots, also in arrival order, over a shared request bus. It uses a request/grant handshake for this. A store is finished once it has been sent. A load stays in the buffer until its fill response comes back. The returned data and message are then written into a response store at the load's own slot number.

When a request is accepted, the core is told the slot number it went into. The core later uses that number to read the result from the response store. Every entry has its own comparator on the line address. A new access (load or store) to a line that still has an outstanding load raises the stall output. So does an access that finds the slot at the allocation pointer still occupied. A separate hold input from the core freezes allocation, so that the reported slot number stays valid while the core is stopped.

Top module: `mshr_array`

## Requirements
- R1: After reset all entries are free, `alloc_idx_o` is 0, `bus_req_o`, `bus_valid_o` and `stall_o` are low, and `rd_valid_o` is low for every index.
- R2: A request is accepted when `req_valid_i` is high and both `stall_o` and `core_hold_i` are low. It takes the entry numbered `alloc_idx_o` in that cycle. `alloc_idx_o` then steps by one after the edge, wrapping from 3 to 0, so successive requests get 0, 1, 2, 3, 0.
- R3: While `core_hold_i` is high, no request is accepted and `alloc_idx_o` does not change.
- R4: `stall_o` is high in the same cycle as a valid request whose line address matches a load entry that is still outstanding (queued or sent). The line address is `req_addr_i[31:5]`, so the word offset in bits 4:0 is ignored. This applies to loads and stores alike. Store entries never cause this stall.
- R5: `stall_o` is high for a valid request whenever the entry at `alloc_idx_o` is still occupied. This includes every cycle in which all four entries are busy.
- R6: `bus_req_o` is high in any cycle in which the oldest unsent entry exists. A clock edge with `bus_req_o` and `bus_gnt_i` both high sends that entry. In the next cycle `bus_valid_o` pulses for one cycle, carrying its index, address, store data, message and store flag (`bus_store_o` = 1 for a store). Entries are sent in arrival order.
- R7: A store entry becomes free at the edge where it is sent, and its slot can be allocated again in the next cycle. A sent load stays occupied until it is filled.
- R8: `fill_valid_i` for an index whose load has been sent frees that entry. It also writes `fill_data_i` and `fill_msg_i` into the response slot of that index and marks the slot valid, visible from the next cycle. A fill for an index whose entry is not awaiting a response is ignored.
- R9: `rd_data_o`, `rd_msg_o` and `rd_valid_o` show the response slot chosen by `rd_idx_i` in the same cycle. `rd_en_i` clears that slot's valid flag at the edge. A fill to the same index in the same cycle wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | New miss or store from the cache |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Request byte address |
| req_wdata_i | input | 32 | Store data |
| req_msg_i | input | 4 | Request message code |
| core_hold_i | input | 1 | Core stall, freezes allocation |
| stall_o | output | 1 | Request cannot be taken this cycle |
| alloc_idx_o | output | 2 | Entry that an accepted request occupies |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_valid_o | output | 1 | Sent entry valid on the bus |
| bus_store_o | output | 1 | Sent entry is a store |
| bus_idx_o | output | 2 | Index of the sent entry |
| bus_addr_o | output | 32 | Address of the sent entry |
| bus_wdata_o | output | 32 | Store data of the sent entry |
| bus_msg_o | output | 4 | Message of the sent entry |
| fill_valid_i | input | 1 | Fill response present |
| fill_idx_i | input | 2 | Entry the fill belongs to |
| fill_data_i | input | 32 | Fill data |
| fill_msg_i | input | 4 | Fill message |
| rd_en_i | input | 1 | Core consumes a response slot |
| rd_idx_i | input | 2 | Response slot to read |
| rd_valid_o | output | 1 | Selected slot holds an unread fill |
| rd_data_o | output | 32 | Selected slot data |
| rd_msg_o | output | 4 | Selected slot message |

## Verification
Two results are combinational in the cycle of the stimulus: `stall_o`, and the response read-out selected by `rd_idx_i`. The allocation pointer, the entry states and the response valid flags change at the next edge. A granted send shows up on `bus_valid_o` exactly one cycle after the grant edge. A fill becomes readable one cycle after its edge. The bench drives every input just after a falling edge and compares all outputs 1 ns later against a behavioural model. It then advances the model by one edge, so each result is checked in the cycle it is due and never earlier.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    // Life cycle of one outstanding-request entry
    typedef enum logic [1:0] {
        ENT_FREE   = 2'd0,  // slot available
        ENT_QUEUED = 2'd1,  // waiting to be sent on the bus
        ENT_WAIT   = 2'd2   // load sent, waiting for its fill
    } ent_state_e;

endpackage

// File: rtl/mshr_line_match.sv
module mshr_line_match #(
    parameter int NUM_ENT = 4,
    parameter int LINE_W  = 27
) (
    input  logic [NUM_ENT-1:0][LINE_W-1:0] ent_line_i,
    input  logic [NUM_ENT-1:0]             ent_watch_i,
    input  logic [LINE_W-1:0]              probe_line_i,
    output logic                           hit_o
);

    logic [NUM_ENT-1:0] hit_vec;

    // One comparator per entry, qualified by the entry's watch flag
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign hit_vec[g] = ent_watch_i[g] && (ent_line_i[g] == probe_line_i);
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/mshr_resp_store.sv
module mshr_resp_store #(
    parameter int  NUM_ENT = 4,
    parameter int  DATA_W  = 32,
    parameter int  MSG_W   = 4,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fill_en_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic [MSG_W-1:0]  fill_msg_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [MSG_W-1:0]  rd_msg_o
);

    typedef struct packed {
        logic [NUM_ENT-1:0]             vld;
        logic [NUM_ENT-1:0][DATA_W-1:0] data;
        logic [NUM_ENT-1:0][MSG_W-1:0]  msg;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (rd_en_i) begin
            slot_d.vld[rd_idx_i] = 1'b0;
        end
        // a fill arriving in the same cycle overrides the clear
        if (fill_en_i) begin
            slot_d.vld[fill_idx_i]  = 1'b1;
            slot_d.data[fill_idx_i] = fill_data_i;
            slot_d.msg[fill_idx_i]  = fill_msg_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign rd_valid_o = slot_q.vld[rd_idx_i];
    assign rd_data_o  = slot_q.data[rd_idx_i];
    assign rd_msg_o   = slot_q.msg[rd_idx_i];

endmodule

// File: rtl/mshr_array.sv
module mshr_array
    import mshr_pkg::*;
#(
    parameter int  NUM_ENT    = 4,
    parameter int  ADDR_W     = 32,
    parameter int  DATA_W     = 32,
    parameter int  MSG_W      = 4,
    parameter int  LINE_OFF_W = 5,
    localparam int IDX_W      = $clog2(NUM_ENT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_store_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [MSG_W-1:0]  req_msg_i,
    input  logic              core_hold_i,
    output logic              stall_o,
    output logic [IDX_W-1:0]  alloc_idx_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              bus_valid_o,
    output logic              bus_store_o,
    output logic [IDX_W-1:0]  bus_idx_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [MSG_W-1:0]  bus_msg_o,
    input  logic              fill_valid_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic [MSG_W-1:0]  fill_msg_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [MSG_W-1:0]  rd_msg_o
);

    localparam int LINE_W = ADDR_W - LINE_OFF_W;

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        ent_state_e        st;
        logic              store;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [MSG_W-1:0]  msg;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_ENT-1:0] ent;
        idx_t               alloc;
        idx_t               drain;
        logic               bvalid;
        logic               bstore;
        idx_t               bidx;
        logic [ADDR_W-1:0]  baddr;
        logic [DATA_W-1:0]  bwdata;
        logic [MSG_W-1:0]   bmsg;
    } core_t;

    core_t state_d, state_q;

    function automatic idx_t step_idx(idx_t i);
        return (i == idx_t'(NUM_ENT - 1)) ? '0 : i + idx_t'(1);
    endfunction

    // per-entry views for the comparators and the checker
    logic [NUM_ENT-1:0][LINE_W-1:0] ent_line;
    logic [NUM_ENT-1:0]             ent_watch;
    logic [NUM_ENT-1:0]             ent_busy;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_view
        assign ent_line[g]  = state_q.ent[g].addr[ADDR_W-1:LINE_OFF_W];
        assign ent_watch[g] = (state_q.ent[g].st != ENT_FREE) && !state_q.ent[g].store;
        assign ent_busy[g]  = (state_q.ent[g].st != ENT_FREE);
    end

    logic line_hit;

    mshr_line_match #(
        .NUM_ENT (NUM_ENT),
        .LINE_W  (LINE_W)
    ) u_match (
        .ent_line_i   (ent_line),
        .ent_watch_i  (ent_watch),
        .probe_line_i (req_addr_i[ADDR_W-1:LINE_OFF_W]),
        .hit_o        (line_hit)
    );

    logic slot_taken;
    logic accept;
    logic send;
    logic fill_ok;
    ent_t head_ent;

    assign slot_taken = (state_q.ent[state_q.alloc].st != ENT_FREE);
    assign stall_o    = req_valid_i && (line_hit || slot_taken);
    assign accept     = req_valid_i && !line_hit && !slot_taken && !core_hold_i;
    assign head_ent   = state_q.ent[state_q.drain];
    assign bus_req_o  = (head_ent.st == ENT_QUEUED);
    assign send       = bus_req_o && bus_gnt_i;
    assign fill_ok    = fill_valid_i && (state_q.ent[fill_idx_i].st == ENT_WAIT);

    always_comb begin
        state_d        = state_q;
        state_d.bvalid = 1'b0;

        if (accept) begin
            state_d.ent[state_q.alloc].st    = ENT_QUEUED;
            state_d.ent[state_q.alloc].store = req_store_i;
            state_d.ent[state_q.alloc].addr  = req_addr_i;
            state_d.ent[state_q.alloc].wdata = req_wdata_i;
            state_d.ent[state_q.alloc].msg   = req_msg_i;
            state_d.alloc                    = step_idx(state_q.alloc);
        end

        if (send) begin
            state_d.bvalid = 1'b1;
            state_d.bstore = head_ent.store;
            state_d.bidx   = state_q.drain;
            state_d.baddr  = head_ent.addr;
            state_d.bwdata = head_ent.wdata;
            state_d.bmsg   = head_ent.msg;
            // write-through stores need no answer; loads wait for a fill
            state_d.ent[state_q.drain].st = head_ent.store ? ENT_FREE : ENT_WAIT;
            state_d.drain  = step_idx(state_q.drain);
        end

        if (fill_ok) begin
            state_d.ent[fill_idx_i].st = ENT_FREE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign alloc_idx_o = state_q.alloc;
    assign bus_valid_o = state_q.bvalid;
    assign bus_store_o = state_q.bstore;
    assign bus_idx_o   = state_q.bidx;
    assign bus_addr_o  = state_q.baddr;
    assign bus_wdata_o = state_q.bwdata;
    assign bus_msg_o   = state_q.bmsg;

    mshr_resp_store #(
        .NUM_ENT (NUM_ENT),
        .DATA_W  (DATA_W),
        .MSG_W   (MSG_W)
    ) u_resp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fill_en_i   (fill_ok),
        .fill_idx_i  (fill_idx_i),
        .fill_data_i (fill_data_i),
        .fill_msg_i  (fill_msg_i),
        .rd_en_i     (rd_en_i),
        .rd_idx_i    (rd_idx_i),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .rd_msg_o    (rd_msg_o)
    );

endmodule

// File: rtl/mshr_array_chk.sv
module mshr_array_chk #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               req_valid_i,
    input logic               core_hold_i,
    input logic               stall_o,
    input logic [IDX_W-1:0]   alloc_idx_o,
    input logic               bus_req_o,
    input logic               bus_gnt_i,
    input logic               bus_valid_o,
    input logic [NUM_ENT-1:0] ent_busy
);

    p_accept_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && !stall_o && !core_hold_i |=> alloc_idx_o != $past(alloc_idx_o));

    p_hold_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_hold_i |=> $stable(alloc_idx_o));

    p_full_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && (&ent_busy) |-> stall_o);

    p_send_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && bus_gnt_i |=> bus_valid_o);

    p_no_stray_send_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_req_o && bus_gnt_i) |=> !bus_valid_o);

    p_req_has_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> (|ent_busy));

endmodule

bind mshr_array mshr_array_chk #(
    .NUM_ENT (NUM_ENT),
    .IDX_W   (IDX_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .core_hold_i (core_hold_i),
    .stall_o     (stall_o),
    .alloc_idx_o (alloc_idx_o),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_valid_o (bus_valid_o),
    .ent_busy    (ent_busy)
);

// File: tb/mshr_array_tb_top.sv
`timescale 1ns/1ps
module mshr_array_tb_top;

    localparam int NE = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int MW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_store = 1'b0, core_hold = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [MW-1:0] req_msg = '0;
    logic          bus_gnt = 1'b0, fill_valid = 1'b0, rd_en = 1'b0;
    logic [IW-1:0] fill_idx = '0, rd_idx = '0;
    logic [DW-1:0] fill_data = '0;
    logic [MW-1:0] fill_msg = '0;

    logic          stall, bus_req, bus_valid, bus_store, rd_valid;
    logic [IW-1:0] alloc_idx, bus_idx;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, rd_data;
    logic [MW-1:0] bus_msg, rd_msg;

    always #4 clk = ~clk;  // 125 MHz

    mshr_array dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_store_i(req_store), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_msg_i(req_msg), .core_hold_i(core_hold),
        .stall_o(stall), .alloc_idx_o(alloc_idx),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_valid_o(bus_valid),
        .bus_store_o(bus_store), .bus_idx_o(bus_idx), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_msg_o(bus_msg),
        .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_data_i(fill_data),
        .fill_msg_i(fill_msg), .rd_en_i(rd_en), .rd_idx_i(rd_idx),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_msg_o(rd_msg)
    );

    // behavioural reference: 0 free, 1 queued, 2 waiting for fill
    int            m_st[NE];
    bit            m_store[NE];
    logic [AW-1:0] m_addr[NE];
    logic [DW-1:0] m_wdata[NE];
    logic [MW-1:0] m_msg[NE];
    int            m_alloc, m_drain;
    bit            e_bv, e_bstore;
    int            e_bidx;
    logic [AW-1:0] e_baddr;
    logic [DW-1:0] e_bwdata;
    logic [MW-1:0] e_bmsg;
    bit            r_vld[NE];
    logic [DW-1:0] r_data[NE];
    logic [MW-1:0] r_msg[NE];

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NE; i++) begin
            m_st[i] = 0; m_store[i] = 0; m_addr[i] = '0; m_wdata[i] = '0; m_msg[i] = '0;
            r_vld[i] = 0; r_data[i] = '0; r_msg[i] = '0;
        end
        m_alloc = 0; m_drain = 0;
        e_bv = 0; e_bstore = 0; e_bidx = 0; e_baddr = '0; e_bwdata = '0; e_bmsg = '0;
    endtask

    function automatic bit m_line_hit();
        for (int i = 0; i < NE; i++)
            if (m_st[i] != 0 && !m_store[i] && m_addr[i][AW-1:5] == req_addr[AW-1:5])
                return 1;
        return 0;
    endfunction

    function automatic bit m_stall();
        return req_valid && (m_line_hit() || m_st[m_alloc] != 0);
    endfunction

    task automatic compare_all();
        chk(m_line_hit() ? "R4" : "R5", "stall_o", stall, m_stall());
        chk("R2", "alloc_idx_o", alloc_idx, m_alloc);
        chk("R6", "bus_req_o", bus_req, m_st[m_drain] == 1);
        chk("R6", "bus_valid_o", bus_valid, e_bv);
        if (e_bv) begin
            chk("R6", "bus_idx_o", bus_idx, e_bidx);
            chk("R6", "bus_store_o", bus_store, e_bstore);
            chk("R6", "bus_addr_o", bus_addr, e_baddr);
            chk("R6", "bus_wdata_o", bus_wdata, e_bwdata);
            chk("R6", "bus_msg_o", bus_msg, e_bmsg);
        end
        chk("R8", "rd_valid_o", rd_valid, r_vld[rd_idx]);
        chk("R8", "rd_data_o", rd_data, r_data[rd_idx]);
        chk("R8", "rd_msg_o", rd_msg, r_msg[rd_idx]);
    endtask

    task automatic model_edge();
        bit acc, snd, fok;
        if (!rst_n) begin
            model_reset();
            return;
        end
        acc = req_valid && !m_stall() && !core_hold;
        snd = (m_st[m_drain] == 1) && bus_gnt;
        fok = fill_valid && (m_st[fill_idx] == 2);
        e_bv = 0;
        if (snd) begin
            e_bv = 1; e_bidx = m_drain; e_bstore = m_store[m_drain];
            e_baddr = m_addr[m_drain]; e_bwdata = m_wdata[m_drain]; e_bmsg = m_msg[m_drain];
            m_st[m_drain] = m_store[m_drain] ? 0 : 2;
            m_drain = (m_drain + 1) % NE;
        end
        if (acc) begin
            m_st[m_alloc] = 1; m_store[m_alloc] = req_store; m_addr[m_alloc] = req_addr;
            m_wdata[m_alloc] = req_wdata; m_msg[m_alloc] = req_msg;
            m_alloc = (m_alloc + 1) % NE;
        end
        if (rd_en) r_vld[rd_idx] = 0;
        if (fok) begin
            m_st[fill_idx] = 0; r_vld[fill_idx] = 1;
            r_data[fill_idx] = fill_data; r_msg[fill_idx] = fill_msg;
        end
    endtask

    // compare after settling, advance the model, move to the next falling edge
    task automatic tick();
        #1;
        compare_all();
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 0; req_store = 0; core_hold = 0; bus_gnt = 0;
        fill_valid = 0; rd_en = 0;
    endtask

    task automatic put_req(bit st, int line, int off, logic [DW-1:0] d, logic [MW-1:0] m);
        req_valid = 1; req_store = st;
        req_addr = (AW'(line) << 5) | AW'(off);
        req_wdata = d; req_msg = m;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        idle();
        tick();
        tick();
        // R1: reset state
        #1;
        chk("R1", "alloc_idx_o", alloc_idx, 0);
        chk("R1", "stall_o", stall, 0);
        chk("R1", "bus_req_o", bus_req, 0);
        chk("R1", "bus_valid_o", bus_valid, 0);
        for (int i = 0; i < NE; i++) begin
            rd_idx = IW'(i);
            #1 chk("R1", "rd_valid_o", rd_valid, 0);
        end
        rd_idx = '0;
        rst_n = 1;
        tick();

        // R3: a held request is not taken
        put_req(0, 1, 0, 32'h0, 4'h1); core_hold = 1;
        tick();
        #1 chk("R3", "alloc_idx_o held", alloc_idx, 0);
        chk("R3", "no entry queued", bus_req, 0);
        core_hold = 0;

        // R2 / R5: four loads fill the ring, the fifth stalls
        for (int i = 0; i < NE; i++) begin
            #1 chk("R2", "alloc order", alloc_idx, i);
            put_req(0, i + 1, 4, 32'h0, 4'(i + 2));
            tick();
        end
        put_req(0, 9, 0, 32'h0, 4'h7);
        #1 chk("R5", "full stall", stall, 1);
        tick();
        idle();

        // R6: send all four in order
        bus_gnt = 1;
        repeat (6) tick();
        bus_gnt = 0;

        // R4: same line, other word, load and store both stall
        put_req(0, 2, 12, 32'h0, 4'h3);
        #1 chk("R4", "load same line", stall, 1);
        tick();
        put_req(1, 3, 8, 32'hDEAD, 4'h3);
        #1 chk("R4", "store same line", stall, 1);
        tick();
        idle();

        // R8: fill entry 2, then a stale fill to it is dropped
        fill_valid = 1; fill_idx = 2; fill_data = 32'hCAFE0002; fill_msg = 4'h9;
        rd_idx = 2;
        tick();
        fill_data = 32'h11111111; fill_msg = 4'h1;
        #1 chk("R8", "filled slot valid", rd_valid, 1);
        tick();
        fill_valid = 0;
        #1 chk("R8", "stale fill ignored", rd_data, 32'hCAFE0002);
        tick();

        // R9: read clears, a same-cycle fill keeps the flag
        rd_en = 1;
        tick();
        rd_en = 0;
        #1 chk("R9", "read clears valid", rd_valid, 0);
        rd_idx = 0; rd_en = 1;
        fill_valid = 1; fill_idx = 0; fill_data = 32'hBEEF0000; fill_msg = 4'h5;
        tick();
        idle();
        #1 chk("R9", "fill beats clear", rd_valid, 1);
        fill_valid = 1; fill_idx = 1; tick();
        fill_idx = 3; tick();
        idle();

        // R7: a sent store frees its slot at once; stores never block a line
        put_req(1, 20, 0, 32'h5555AAAA, 4'hC);
        tick();
        put_req(0, 20, 4, 32'h0, 4'hD);
        #1 chk("R4", "store entry no line stall", stall, 0);
        tick();
        idle();
        bus_gnt = 1; tick(); tick(); bus_gnt = 0;
        put_req(0, 30, 0, 32'h0, 4'h2); tick();
        put_req(0, 31, 0, 32'h0, 4'h2); tick();
        put_req(0, 32, 0, 32'h0, 4'h2);
        #1 chk("R7", "store slot reused", stall, 0);
        tick();
        idle();
        bus_gnt = 1; repeat (4) tick(); bus_gnt = 0;
        for (int i = 0; i < NE; i++) begin
            fill_valid = 1; fill_idx = IW'(i); tick();
        end
        idle();

        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            req_valid  = ($urandom % 2) == 0;
            req_store  = ($urandom % 3) == 0;
            req_addr   = (AW'($urandom % 6) << 5) | AW'($urandom % 32);
            req_wdata  = $urandom;
            req_msg    = MW'($urandom);
            core_hold  = ($urandom % 8) == 0;
            bus_gnt    = ($urandom % 2) == 0;
            fill_valid = ($urandom % 3) == 0;
            fill_idx   = IW'($urandom);
            fill_data  = $urandom;
            fill_msg   = MW'($urandom);
            rd_en      = ($urandom % 4) == 0;
            rd_idx     = IW'($urandom);
            tick();
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule